// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two binary32 floating-point operands and delivers the correctly rounded result. A result is available a fixed four cycles after the operands are presented. The datapath is a four-stage pipeline, so a new operation can be issued on every cycle. Stage one classifies the operands, orders them by magnitude and shifts the smaller significand right until the exponents match. It keeps guard, round and sticky bits as it does so. Stage two adds or subtracts the aligned significands. Stage three normalizes the sum and clamps the exponent at the denormal boundary. Stage four rounds to nearest with ties to even, renormalizes when rounding carries out of the significand, and resolves the special operands.

Each operand word holds the sign in bit 31, an 8-bit exponent with bias 127 in bits 30..23, and a 23-bit fraction in bits 22..0. An exponent field of 0 marks a zero or denormal operand, whose hidden bit is 0. An exponent field of 255 marks an infinity when the fraction is zero and a NaN when it is not. Three flag outputs travel with each result: overflow, tiny result and invalid operation.

Top module: `fpadd_sp`

## Requirements
- R1: Every cycle with `in_valid` high gives exactly one cycle of `out_valid` high, four rising edges later. Back-to-back issues give back-to-back results in issue order.
- R2: For finite operands that do not overflow, `res` is the exact sum rounded to nearest binary32, with `flag_ovf`, `flag_tiny` and `flag_inv` low unless another requirement sets one of them.
- R3: With `op_sub` = 1 the result is `op_a` minus `op_b`, which is computed as `op_a` plus `op_b` with the sign bit inverted.
- R4: When the exact sum lies halfway between two representable values, the one with an even (zero) last fraction bit is returned. For example 0x3F800000 + 0x33800000 gives 0x3F800000, and 0x3F800001 + 0x33800000 gives 0x3F800002.
- R5: Denormal operands are used with hidden bit 0 and exponent 1. A nonzero finite result whose exponent field is 0 is returned as a denormal and raises `flag_tiny`.
- R6: An exact-zero result of operands with opposite effective signs is +0 (0x00000000). A sum of two zeros of the same effective sign keeps that sign.
- R7: A finite result whose rounded exponent reaches 255 returns infinity with the sign of the result and raises `flag_ovf`.
- R8: A NaN operand, or infinities of opposite effective sign, returns the quiet NaN 0x7FC00000 and raises `flag_inv` only.
- R9: An infinity operand combined with a finite value, or with an infinity of the same effective sign, returns that infinity with no flag raised.
- R10: When rounding carries out of the 24-bit significand, the result is renormalized and the exponent goes up by one. For example 0x3FFFFFFF + 0x33800000 gives 0x40000000.
- R11: While `rst_n` is low at a rising edge, `out_valid`, `res` and all flags are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on `op_a`, `op_b`, `op_sub` are captured this cycle |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| op_sub | input | 1 | 1 selects subtraction, 0 addition |
| out_valid | output | 1 | `res` and the flags are valid this cycle |
| res | output | 32 | Rounded result, binary32 |
| flag_ovf | output | 1 | Result overflowed to infinity |
| flag_tiny | output | 1 | Result is a nonzero denormal |
| flag_inv | output | 1 | Invalid operation, quiet NaN returned |

## Verification
Every result is due on the fourth rising edge after the edge that captures its operands, and the flags arrive on the same edge. The bench drives operands at falling edges and pushes a reference result onto a queue at the same moment. At each falling edge it pops the queue whenever `out_valid` is high, so the stream checks hold the pipeline to issue order with no gaps. A separate directed test counts the rising edges between issue and `out_valid` and expects exactly four. It also expects `out_valid` to drop on the following cycle. The reference is exact integer arithmetic on a 320-bit fixed-point image of both operands, rounded in the bench, and it covers a grid of exponents, fractions and signs that includes every reserved code.

// File: rtl/fpadd_pkg.sv
// Package: shared definitions for the binary32 adder pipeline.
// Assumes: operands use sign | biased exponent | fraction ordering.
package fpadd_pkg;
    // Operand-class tag carried down the pipeline beside the datapath.
    typedef enum logic [1:0] {
        CLS_FIN = 2'd0,   // finite result path (zeros and denormals included)
        CLS_NAN = 2'd1,   // result forced to the quiet NaN
        CLS_INF = 2'd2    // result forced to a signed infinity
    } cls_e;
endpackage

// File: rtl/fpa_align.sv
// Module: stage 1, operand classification and exponent alignment.
// Orders the operands by magnitude, and shifts the smaller significand right
// by the exponent difference with guard, round and sticky bits appended.
// Assumes: denormals are treated as exponent 1 with hidden bit 0.
module fpa_align
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic                 op_sub,
    output logic                 v_o,
    output cls_e                 cls_o,
    output logic                 sign_o,
    output logic                 eff_sub_o,
    output logic [EXP_W-1:0]     exp_o,
    output logic [FRAC_W+3:0]    big_o,
    output logic [FRAC_W+3:0]    small_o
);
    localparam int TOT_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W = FRAC_W + 1;
    localparam int WRK_W = SIG_W + 3;

    logic               sgn_a, sgn_b;
    logic [EXP_W-1:0]   ex_a, ex_b, efx_a, efx_b;
    logic [FRAC_W-1:0]  fr_a, fr_b;
    logic               nan_a, nan_b, inf_a, inf_b;
    logic               a_big;
    logic [EXP_W-1:0]   ex_l, ex_s, diff;
    logic [SIG_W-1:0]   sig_l, sig_s;
    logic               sgn_l;
    logic [WRK_W-1:0]   ext_s, shf_s, lowmask, aligned;
    cls_e               cls_n;
    logic               sign_n;

    // Field split; subtraction flips the sign of the second operand.
    assign sgn_a = op_a[TOT_W-1];
    assign sgn_b = op_b[TOT_W-1] ^ op_sub;
    assign ex_a  = op_a[TOT_W-2 -: EXP_W];
    assign ex_b  = op_b[TOT_W-2 -: EXP_W];
    assign fr_a  = op_a[FRAC_W-1:0];
    assign fr_b  = op_b[FRAC_W-1:0];
    assign nan_a = (&ex_a) && (fr_a != '0);
    assign nan_b = (&ex_b) && (fr_b != '0);
    assign inf_a = (&ex_a) && (fr_a == '0);
    assign inf_b = (&ex_b) && (fr_b == '0);
    assign efx_a = (ex_a == '0) ? EXP_W'(1) : ex_a;
    assign efx_b = (ex_b == '0) ? EXP_W'(1) : ex_b;

    // Magnitude order: the raw exponent|fraction bits sort like the values.
    assign a_big = (op_a[TOT_W-2:0] >= op_b[TOT_W-2:0]);

    // Select larger and smaller operand and their effective exponents.
    always_comb begin
        if (a_big) begin
            ex_l  = efx_a;  ex_s  = efx_b;
            sig_l = {ex_a != '0, fr_a};
            sig_s = {ex_b != '0, fr_b};
            sgn_l = sgn_a;
        end else begin
            ex_l  = efx_b;  ex_s  = efx_a;
            sig_l = {ex_b != '0, fr_b};
            sig_s = {ex_a != '0, fr_a};
            sgn_l = sgn_b;
        end
        diff = ex_l - ex_s;
    end

    // Right shift of the smaller significand with sticky collection.
    always_comb begin
        ext_s   = {sig_s, 3'b000};
        shf_s   = ext_s >> diff;
        lowmask = ~({WRK_W{1'b1}} << diff);
        if (diff >= EXP_W'(WRK_W))
            aligned = {{(WRK_W-1){1'b0}}, |sig_s};
        else
            aligned = shf_s | {{(WRK_W-1){1'b0}}, |(ext_s & lowmask)};
    end

    // Special-operand resolution: NaN beats infinity beats finite.
    always_comb begin
        cls_n  = CLS_FIN;
        sign_n = sgn_l;
        if (nan_a || nan_b || (inf_a && inf_b && (sgn_a != sgn_b))) begin
            cls_n  = CLS_NAN;
            sign_n = 1'b0;
        end else if (inf_a) begin
            cls_n  = CLS_INF;
            sign_n = sgn_a;
        end else if (inf_b) begin
            cls_n  = CLS_INF;
            sign_n = sgn_b;
        end
    end

    // Stage-1 pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o       <= 1'b0;
            cls_o     <= CLS_FIN;
            sign_o    <= 1'b0;
            eff_sub_o <= 1'b0;
            exp_o     <= '0;
            big_o     <= '0;
            small_o   <= '0;
        end else begin
            v_o       <= in_valid;
            cls_o     <= cls_n;
            sign_o    <= sign_n;
            eff_sub_o <= (sgn_a != sgn_b);
            exp_o     <= ex_l;
            big_o     <= {sig_l, 3'b000};
            small_o   <= aligned;
        end
    end

    // R2: after alignment the smaller operand never exceeds the larger one.
    assert_align_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (v_o && cls_o == CLS_FIN) |-> (big_o >= small_o));
endmodule

// File: rtl/fpa_sum.sv
// Module: stage 2, significand addition or subtraction.
// Assumes: big_i >= small_i, so the difference never goes negative.
// A zero difference of opposite-sign operands gets a positive sign.
module fpa_sum
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  cls_e              cls_i,
    input  logic              sign_i,
    input  logic              eff_sub_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W+3:0] big_i,
    input  logic [FRAC_W+3:0] small_i,
    output logic              v_o,
    output cls_e              cls_o,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [FRAC_W+4:0] sum_o
);
    localparam int WRK_W = FRAC_W + 4;

    logic [WRK_W:0] raw;
    logic           sgn_n;

    // Add or subtract, then apply the zero-sign rule.
    always_comb begin
        if (eff_sub_i)
            raw = {1'b0, big_i} - {1'b0, small_i};
        else
            raw = {1'b0, big_i} + {1'b0, small_i};
        sgn_n = sign_i;
        if (eff_sub_i && raw == '0 && cls_i == CLS_FIN)
            sgn_n = 1'b0;
    end

    // Stage-2 pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            cls_o  <= CLS_FIN;
            sign_o <= 1'b0;
            exp_o  <= '0;
            sum_o  <= '0;
        end else begin
            v_o    <= v_i;
            cls_o  <= cls_i;
            sign_o <= sgn_n;
            exp_o  <= exp_i;
            sum_o  <= raw;
        end
    end

    // R3: an effective subtraction of ordered operands never carries out.
    assert_sub_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && eff_sub_i && cls_i == CLS_FIN) |=> !sum_o[WRK_W]);
endmodule

// File: rtl/fpa_norm.sv
// Module: stage 3, normalization.
// Shifts right by one on carry-out, or left by the leading-zero count, and
// clamps the left shift so the exponent stays at 1 or above. A result with no
// hidden bit after the shift is encoded with exponent 0 (denormal or zero).
// Assumes: exp_i >= 1.
module fpa_norm
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  cls_e              cls_i,
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W+4:0] sum_i,
    output logic              v_o,
    output cls_e              cls_o,
    output logic              sign_o,
    output logic [EXP_W:0]    exp_o,
    output logic [FRAC_W+3:0] sig_o
);
    localparam int WRK_W = FRAC_W + 4;
    localparam int LZ_W  = $clog2(WRK_W + 1);

    logic [LZ_W-1:0]  lz;
    logic [EXP_W:0]   e_in, limit, lz_w, sh;
    logic [WRK_W-1:0] sig_n;
    logic [EXP_W:0]   exp_n;

    assign e_in  = {1'b0, exp_i};
    assign limit = e_in - (EXP_W+1)'(1);
    assign lz_w  = (EXP_W+1)'(lz);

    // Leading-zero count over the significand below the carry bit.
    always_comb begin
        lz = LZ_W'(WRK_W);
        for (int i = 0; i < WRK_W; i++)
            if (sum_i[i]) lz = LZ_W'(WRK_W - 1 - i);
    end

    // Normalizing shift and exponent adjustment.
    always_comb begin
        sh = (lz_w < limit) ? lz_w : limit;
        if (sum_i[WRK_W]) begin
            sig_n = {sum_i[WRK_W:2], sum_i[1] | sum_i[0]};
            exp_n = e_in + (EXP_W+1)'(1);
        end else begin
            sig_n = sum_i[WRK_W-1:0] << sh;
            exp_n = e_in - sh;
            if (!sig_n[WRK_W-1])
                exp_n = '0;
        end
    end

    // Stage-3 pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            cls_o  <= CLS_FIN;
            sign_o <= 1'b0;
            exp_o  <= '0;
            sig_o  <= '0;
        end else begin
            v_o    <= v_i;
            cls_o  <= cls_i;
            sign_o <= sign_i;
            exp_o  <= exp_n;
            sig_o  <= sig_n;
        end
    end

    // R5: a nonzero exponent always comes with the hidden bit set, and a zero exponent without it.
    assert_norm_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_o && cls_o == CLS_FIN) |-> (sig_o[WRK_W-1] == (exp_o != '0)));
endmodule

// File: rtl/fpa_round.sv
// Module: stage 4, round to nearest-even, renormalize, and pack the result.
// Applies special results and raises the overflow, tiny and invalid flags.
// Assumes: sig_i has the hidden bit at its MSB, or exp_i is 0 for denormals.
module fpa_round
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  v_i,
    input  cls_e                  cls_i,
    input  logic                  sign_i,
    input  logic [EXP_W:0]        exp_i,
    input  logic [FRAC_W+3:0]     sig_i,
    output logic                  v_o,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic                  ovf_o,
    output logic                  tiny_o,
    output logic                  inv_o
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int WRK_W = SIG_W + 3;
    localparam int TOT_W = 1 + EXP_W + FRAC_W;
    localparam logic [EXP_W:0] EXP_TOP = (EXP_W+1)'((1 << EXP_W) - 1);

    logic              up;
    logic [SIG_W:0]    mant;
    logic [EXP_W:0]    e_r;
    logic [FRAC_W-1:0] frac_r;
    logic [TOT_W-1:0]  res_n;
    logic              ovf_n, tiny_n, inv_n;

    // Ties-to-even increment from the last kept bit and the guard/round/sticky bits.
    assign up   = sig_i[2] & (sig_i[3] | sig_i[1] | sig_i[0]);
    assign mant = {1'b0, sig_i[WRK_W-1:3]} + (SIG_W+1)'(up);

    // Renormalization after a rounding carry, and denormal-to-normal promotion.
    always_comb begin
        e_r    = exp_i;
        frac_r = mant[FRAC_W-1:0];
        if (mant[SIG_W]) begin
            e_r    = exp_i + (EXP_W+1)'(1);
            frac_r = mant[FRAC_W:1];
        end else if (exp_i == '0 && mant[SIG_W-1]) begin
            e_r = (EXP_W+1)'(1);
        end
    end

    // Result packing and flag selection.
    always_comb begin
        ovf_n  = 1'b0;
        tiny_n = 1'b0;
        inv_n  = 1'b0;
        if (cls_i == CLS_NAN) begin
            res_n = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
            inv_n = 1'b1;
        end else if (cls_i == CLS_INF) begin
            res_n = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (e_r >= EXP_TOP) begin
            res_n = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf_n = 1'b1;
        end else begin
            res_n  = {sign_i, e_r[EXP_W-1:0], frac_r};
            tiny_n = (e_r == '0) && (frac_r != '0);
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            res_o  <= '0;
            ovf_o  <= 1'b0;
            tiny_o <= 1'b0;
            inv_o  <= 1'b0;
        end else begin
            v_o    <= v_i;
            res_o  <= res_n;
            ovf_o  <= ovf_n;
            tiny_o <= tiny_n;
            inv_o  <= inv_n;
        end
    end

    // R2: at most one flag is raised per result.
    assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> $onehot0({ovf_o, tiny_o, inv_o}));
    // R7: overflow always delivers an infinity encoding.
    assert_ovf_is_inf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (v_o && ovf_o) |-> (res_o[TOT_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
    // R8: the invalid flag always comes with a NaN encoding.
    assert_inv_is_nan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (v_o && inv_o) |-> ((&res_o[TOT_W-2 -: EXP_W]) && res_o[FRAC_W-1:0] != '0));
endmodule

// File: rtl/fpadd_sp.sv
// Module: top of the binary32 add/subtract pipeline.
// Chains align, sum, normalize and round stages; fixed latency of four edges,
// one operation accepted per cycle. Assumes rst_n is synchronous, active low.
module fpadd_sp
    import fpadd_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic                  op_sub,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] res,
    output logic                  flag_ovf,
    output logic                  flag_tiny,
    output logic                  flag_inv
);
    localparam int WRK_W = FRAC_W + 4;

    logic             a_v, a_sign, a_sub;
    cls_e             a_cls;
    logic [EXP_W-1:0] a_exp;
    logic [WRK_W-1:0] a_big, a_small;

    logic             s_v, s_sign;
    cls_e             s_cls;
    logic [EXP_W-1:0] s_exp;
    logic [WRK_W:0]   s_sum;

    logic             n_v, n_sign;
    cls_e             n_cls;
    logic [EXP_W:0]   n_exp;
    logic [WRK_W-1:0] n_sig;

    fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .v_o(a_v), .cls_o(a_cls), .sign_o(a_sign), .eff_sub_o(a_sub),
        .exp_o(a_exp), .big_o(a_big), .small_o(a_small));

    fpa_sum #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .v_i(a_v), .cls_i(a_cls), .sign_i(a_sign),
        .eff_sub_i(a_sub), .exp_i(a_exp), .big_i(a_big), .small_i(a_small),
        .v_o(s_v), .cls_o(s_cls), .sign_o(s_sign), .exp_o(s_exp), .sum_o(s_sum));

    fpa_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .clk(clk), .rst_n(rst_n), .v_i(s_v), .cls_i(s_cls), .sign_i(s_sign),
        .exp_i(s_exp), .sum_i(s_sum),
        .v_o(n_v), .cls_o(n_cls), .sign_o(n_sign), .exp_o(n_exp), .sig_o(n_sig));

    fpa_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .clk(clk), .rst_n(rst_n), .v_i(n_v), .cls_i(n_cls), .sign_i(n_sign),
        .exp_i(n_exp), .sig_i(n_sig),
        .v_o(out_valid), .res_o(res), .ovf_o(flag_ovf), .tiny_o(flag_tiny),
        .inv_o(flag_inv));

    // R1: every accepted operation leaves the pipeline exactly four edges later.
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##4 out_valid);
endmodule

// File: tb/sim_fpadd_sp.sv
// Bench: grid sweep of binary32 add/subtract against an exact integer model.
module sim_fpadd_sp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        op_sub = 1'b0;
    logic        out_valid, flag_ovf, flag_tiny, flag_inv;
    logic [31:0] res;

    int tests = 0;
    int fails = 0;

    logic [34:0] exp_q[$];
    logic [64:0] opd_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    fpadd_sp u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .out_valid(out_valid), .res(res),
        .flag_ovf(flag_ovf), .flag_tiny(flag_tiny), .flag_inv(flag_inv));

    // Exact reference: {ovf, tiny, inv, result}.
    function automatic logic [34:0] ref_add(input logic [31:0] a, input logic [31:0] b,
                                            input logic sub);
        logic sa, sb, s;
        logic [7:0] ea, eb;
        logic [22:0] fa, fb;
        logic [319:0] ma, mb, m, mask;
        logic [24:0] keep;
        int p, sh, e;
        logic half, sticky;
        sa = a[31]; sb = b[31] ^ sub;
        ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
        if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0) ||
            (ea == 8'hFF && eb == 8'hFF && sa != sb))
            return {3'b001, 32'h7FC00000};
        if (ea == 8'hFF) return {3'b000, sa, 8'hFF, 23'h0};
        if (eb == 8'hFF) return {3'b000, sb, 8'hFF, 23'h0};
        ma = 320'({ea != 0, fa}) << ((ea == 0) ? 0 : ea - 1);
        mb = 320'({eb != 0, fb}) << ((eb == 0) ? 0 : eb - 1);
        if (sa == sb) begin m = ma + mb; s = sa; end
        else if (ma >= mb) begin m = ma - mb; s = sa; end
        else begin m = mb - ma; s = sb; end
        if (m == 0) return {3'b000, (sa == sb) ? sa : 1'b0, 31'h0};
        p = 0;
        for (int i = 0; i < 320; i++) if (m[i]) p = i;
        if (p <= 23) return {1'b0, p < 23, 1'b0, s, m[30:0]};
        sh = p - 23;
        keep = 25'(m >> sh);
        half = m[sh-1];
        mask = (320'b1 << (sh - 1)) - 1;
        sticky = (m & mask) != 0;
        if (half && (sticky || keep[0])) keep = keep + 1;
        e = p - 22;
        if (keep[24]) begin keep = keep >> 1; e = e + 1; end
        if (e >= 255) return {3'b100, s, 8'hFF, 23'h0};
        return {3'b000, s, 8'(e), keep[22:0]};
    endfunction

    task automatic check(input string tag, input logic [34:0] got, input logic [34:0] want);
        tests++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s got res=%h flags=%b expected res=%h flags=%b",
                     tag, got[31:0], got[34:32], want[31:0], want[34:32]);
        end
    endtask

    // Label a sweep vector by the requirement its expected result exercises.
    function automatic string label(input logic [34:0] w, input logic sub);
        if (w[32]) return "R8";
        if (w[34]) return "R7";
        if (w[33]) return "R5";
        if (w[30:23] == 8'hFF) return "R9";
        if (w[30:0] == 0) return "R6";
        return sub ? "R3" : "R2";
    endfunction

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sub,
                         input string tag);
        in_valid = 1'b1; op_a = a; op_b = b; op_sub = sub;
        exp_q.push_back(ref_add(a, b, sub));
        opd_q.push_back({sub, a, b});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Stream checker: results are popped in issue order at falling edges.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R1 unexpected out_valid got 1 expected 0");
            end else begin
                logic [34:0] w;
                string t;
                w = exp_q.pop_front();
                t = tag_q.pop_front();
                void'(opd_q.pop_front());
                check(t, {flag_ovf, flag_tiny, flag_inv, res}, w);
            end
        end
    end

    function automatic logic [31:0] grid(input int i);
        int ex[12] = '{0, 1, 2, 23, 24, 25, 126, 127, 128, 253, 254, 255};
        logic [22:0] fr[5] = '{23'h0, 23'h1, 23'h400000, 23'h7FFFFF, 23'h2AAAAA};
        return {i >= 60, 8'(ex[(i % 60) / 5]), fr[i % 5]};
    endfunction

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R11: reset state.
        check("R11", {flag_ovf, flag_tiny, flag_inv, res}, 35'h0);
        tests++;
        if (out_valid !== 1'b0) begin
            fails++; $display("FAIL R11 out_valid got %b expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: latency of one isolated operation, and a single-cycle pulse.
        issue(32'h3F800000, 32'h40000000, 1'b0, "R2");
        in_valid = 1'b0;
        k = 1;
        while (!out_valid && k < 10) begin @(negedge clk); k++; end
        tests++;
        if (k != 4) begin fails++; $display("FAIL R1 latency got %0d expected 4", k); end
        @(negedge clk);
        tests++;
        if (out_valid !== 1'b0) begin
            fails++; $display("FAIL R1 pulse width got out_valid=%b expected 0", out_valid);
        end

        // Directed corner cases.
        issue(32'h3F800000, 32'h33800000, 1'b0, "R4");   // tie, stays even
        issue(32'h3F800001, 32'h33800000, 1'b0, "R4");   // tie, rounds up to even
        issue(32'h3FFFFFFF, 32'h33800000, 1'b0, "R10");  // rounding carry
        issue(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R7");   // overflow
        issue(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, "R7");   // negative overflow
        issue(32'h00000003, 32'h00000001, 1'b1, "R5");   // denormal difference
        issue(32'h00800000, 32'h00000001, 1'b1, "R5");   // normal to denormal
        issue(32'h40490FDB, 32'h40490FDB, 1'b1, "R6");   // x - x = +0
        issue(32'h80000000, 32'h00000000, 1'b1, "R6");   // -0 - +0 = -0
        issue(32'h7F800000, 32'h7F800000, 1'b1, "R8");   // inf - inf
        issue(32'h7FA00000, 32'h3F800000, 1'b0, "R8");   // signalling NaN in
        issue(32'hFF800000, 32'h3F800000, 1'b0, "R9");   // -inf + 1
        issue(32'h3F800000, 32'h3F000000, 1'b1, "R3");   // 1 - 0.5

        // Grid sweep, back to back (R1 ordering checked by the queue).
        for (int i = 0; i < 120; i++)
            for (int j = 0; j < 120; j++)
                for (int s = 0; s < 2; s++) begin
                    logic [34:0] w;
                    w = ref_add(grid(i), grid(j), s[0]);
                    issue(grid(i), grid(j), s[0], label(w, s[0]));
                end
        in_valid = 1'b0;
        repeat (8) @(negedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 results missing got %0d pending expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R1 watchdog expired got hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule